// File: doc/BRIEF.md
# Fault-First Vector Length Truncation Controller

This block sequences the elements of a vectorised load or store issued in fault-first mode. It watches the fault outcome of each element and decides what the effective vector length becomes. It issues element indices one at a time, in order. It waits for each response before moving on.

A fault on the very first element is treated as it would be for a scalar access. The exception is raised, and the vector length stays as requested. A fault on any later element behaves differently:

- the offending access is cancelled,
- no exception is raised,
- the vector length shrinks to the number of elements already completed.

The implementation may also ask to stop early through a voluntary stop input. That request can only take effect after at least one element has completed, so the result is never zero. A parameter selects a minimal variant that always stops after the first element.

Requests that cannot be fault-first are refused with an illegal flag, and no element is issued. There are two such requests: those with a vector base operand (indexed addressing), and those made in one-element-at-a-time mode.

Top module: `ffvl_top`

## Requirements
- R1: After reset, done, elemReq, exception, illegal and cancel are 0 and finalVl is 0.
- R2: With no faults, elements 0 to reqVl-1 are requested in order on elemIdx. wbEn is 1 in each element's acknowledge cycle. done is 1 in the cycle after the last acknowledge, with finalVl equal to reqVl and exception 0.
- R3: A fault on element 0 sets exception to 1 and leaves finalVl equal to reqVl. In that acknowledge cycle, cancel and wbEn are both 0.
- R4: A fault on element i with i of at least 1 pulses cancel in the acknowledge cycle with wbEn 0. It ends the sequence with finalVl equal to i and exception 0.
- R5: stopReq high during the fault-free acknowledge of element i, when that element is not the last one, ends the sequence with finalVl equal to i+1.
- R6: When elemFault and stopReq are both high in the same acknowledge cycle, the fault takes priority. For i of at least 1 this gives cancel 1 and finalVl equal to i.
- R7: start with baseIsVec set requests no element. In the following cycle it gives done 1, illegal 1 and finalVl equal to reqVl.
- R8: start with vertMode set is refused in the same way as R7.
- R9: While a sequence is running, start has no effect. elemReq is 0 in the done cycle and afterwards.
- R10: With FORCE_SINGLE set, a fault-free element 0 ends the sequence with finalVl equal to 1.
- R11: start with reqVl equal to 0 requests no element and completes with done 1 and finalVl 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a fault-first sequence (taken only when idle) |
| reqVl | input | VLW | Requested vector length |
| baseIsVec | input | 1 | Base operand is a vector (indexed addressing) |
| vertMode | input | 1 | One-element-at-a-time execution mode |
| elemReq | output | 1 | Element access request valid |
| elemIdx | output | VLW | Index of the requested element |
| elemAck | input | 1 | Response for the current element |
| elemFault | input | 1 | The responding element would fault |
| stopReq | input | 1 | Voluntary early-stop request |
| wbEn | output | 1 | Write back the acknowledged element |
| cancel | output | 1 | Cancel the faulting access (element 1 and above) |
| exception | output | 1 | Exception raised by element 0 |
| illegal | output | 1 | Request refused as not fault-first capable |
| done | output | 1 | Sequence complete (one cycle) |
| finalVl | output | VLW | Resulting vector length |

## Verification
Two decisions can land in the same acknowledge cycle: a fault, and a voluntary stop request. Each picks a different final length. The bench raises elemFault and stopReq together on element 1 and expects the fault rule to win: cancel is high and the final length is 1, not 2. A second overlap comes from a start pulse that arrives while a sequence is still running. That pulse must not disturb the length in flight, and the bench checks this after completion.

// File: rtl/ffvl_pkg.sv
package ffvl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } ffState_e;

  typedef enum logic [1:0] {
    VL_REQ_IN   = 2'd0,
    VL_REQ_REG  = 2'd1,
    VL_CUR_IDX  = 2'd2,
    VL_NEXT_IDX = 2'd3
  } vlSel_e;

  typedef struct packed {
    logic   ldReq;
    logic   incCnt;
    logic   vlLoad;
    vlSel_e vlSel;
    logic   setExc;
    logic   setIll;
  } ffStrobe_t;

endpackage

// File: rtl/ffvl_dpath.sv
module ffvl_dpath
  import ffvl_pkg::*;
#(
  parameter int VLW = 5
) (
  input  logic           clk,
  input  logic           rstN,
  input  ffStrobe_t      stb,
  input  logic [VLW-1:0] reqVl,
  output logic [VLW-1:0] elemCnt,
  output logic [VLW-1:0] vlOut,
  output logic           excOut,
  output logic           illOut,
  output logic           cntZero,
  output logic           lastElem,
  output logic           reqInZero
);

  logic [VLW-1:0] reqVlReg;
  logic [VLW-1:0] vlReg;
  logic [VLW-1:0] vlNext;
  logic [VLW-1:0] cntPlus;
  logic           excReg;
  logic           illReg;

  assign cntPlus   = elemCnt + VLW'(1);
  assign cntZero   = (elemCnt == '0);
  assign lastElem  = (cntPlus == reqVlReg);
  assign reqInZero = (reqVl == '0);

  always_comb begin
    unique case (stb.vlSel)
      VL_REQ_IN:   vlNext = reqVl;
      VL_REQ_REG:  vlNext = reqVlReg;
      VL_CUR_IDX:  vlNext = elemCnt;
      VL_NEXT_IDX: vlNext = cntPlus;
      default:     vlNext = reqVlReg;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqVlReg <= '0;
      elemCnt  <= '0;
    end else if (stb.ldReq) begin
      reqVlReg <= reqVl;
      elemCnt  <= '0;
    end else if (stb.incCnt) begin
      elemCnt  <= cntPlus;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vlReg  <= '0;
      excReg <= 1'b0;
      illReg <= 1'b0;
    end else begin
      if (stb.vlLoad) vlReg <= vlNext;
      if (stb.ldReq) begin
        excReg <= stb.setExc;
        illReg <= stb.setIll;
      end else begin
        if (stb.setExc) excReg <= 1'b1;
        if (stb.setIll) illReg <= 1'b1;
      end
    end
  end

  assign vlOut  = vlReg;
  assign excOut = excReg;
  assign illOut = illReg;

  AST_TRUNC_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.vlLoad && stb.vlSel == VL_CUR_IDX) |-> (elemCnt != '0)); // R4
  AST_EXC_KEEPS_VL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(excReg) |-> (vlReg == reqVlReg)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    elemCnt <= reqVlReg); // R2

endmodule

// File: rtl/ffvl_ctrl.sv
module ffvl_ctrl
  import ffvl_pkg::*;
#(
  parameter bit FORCE_SINGLE = 1'b0
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      baseIsVec,
  input  logic      vertMode,
  input  logic      elemAck,
  input  logic      elemFault,
  input  logic      stopReq,
  input  logic      cntZero,
  input  logic      lastElem,
  input  logic      reqInZero,
  input  logic      illState,
  output ffStrobe_t stb,
  output logic      elemReqO,
  output logic      wbEnO,
  output logic      cancelO,
  output logic      doneO
);

  ffState_e state, stateNext;
  logic     forceStop;

  generate
    if (FORCE_SINGLE) begin : g_single
      assign forceStop = cntZero;
    end else begin : g_normal
      assign forceStop = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stb       = '0;
    stb.vlSel = VL_REQ_REG;
    stateNext = state;
    wbEnO     = 1'b0;
    cancelO   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stb.ldReq = 1'b1;
          if (baseIsVec || vertMode) begin
            stb.setIll  = 1'b1;
            stb.vlLoad  = 1'b1;
            stb.vlSel   = VL_REQ_IN;
            stateNext   = ST_DONE;
          end else if (reqInZero) begin
            stb.vlLoad  = 1'b1;
            stb.vlSel   = VL_REQ_IN;
            stateNext   = ST_DONE;
          end else begin
            stateNext   = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (elemAck) begin
          if (elemFault) begin
            stb.vlLoad = 1'b1;
            stateNext  = ST_DONE;
            if (cntZero) begin
              stb.setExc = 1'b1;
              stb.vlSel  = VL_REQ_REG;
            end else begin
              cancelO    = 1'b1;
              stb.vlSel  = VL_CUR_IDX;
            end
          end else begin
            wbEnO      = 1'b1;
            stb.incCnt = 1'b1;
            if (lastElem) begin
              stb.vlLoad = 1'b1;
              stb.vlSel  = VL_REQ_REG;
              stateNext  = ST_DONE;
            end else if (stopReq || forceStop) begin
              stb.vlLoad = 1'b1;
              stb.vlSel  = VL_NEXT_IDX;
              stateNext  = ST_DONE;
            end
          end
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign elemReqO = (state == ST_RUN);
  assign doneO    = (state == ST_DONE);

  AST_CANCEL_LATER_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    cancelO |-> !cntZero); // R4
  AST_FAULT_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (elemReqO && elemAck && elemFault) |=> doneO); // R6
  AST_ILLEGAL_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    illState |-> !elemReqO); // R7
  AST_NO_REQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    doneO |=> !elemReqO); // R9

endmodule

// File: rtl/ffvl_top.sv
module ffvl_top
  import ffvl_pkg::*;
#(
  parameter int MAX_VL       = 16,
  parameter bit FORCE_SINGLE = 1'b0,
  localparam int VLW         = $clog2(MAX_VL + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [VLW-1:0] reqVl,
  input  logic           baseIsVec,
  input  logic           vertMode,
  output logic           elemReq,
  output logic [VLW-1:0] elemIdx,
  input  logic           elemAck,
  input  logic           elemFault,
  input  logic           stopReq,
  output logic           wbEn,
  output logic           cancel,
  output logic           exception,
  output logic           illegal,
  output logic           done,
  output logic [VLW-1:0] finalVl
);

  ffStrobe_t stb;
  logic      cntZero;
  logic      lastElem;
  logic      reqInZero;

  ffvl_ctrl #(.FORCE_SINGLE(FORCE_SINGLE)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .baseIsVec(baseIsVec),
    .vertMode(vertMode), .elemAck(elemAck), .elemFault(elemFault),
    .stopReq(stopReq), .cntZero(cntZero), .lastElem(lastElem),
    .reqInZero(reqInZero), .illState(illegal), .stb(stb),
    .elemReqO(elemReq), .wbEnO(wbEn), .cancelO(cancel), .doneO(done)
  );

  ffvl_dpath #(.VLW(VLW)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .reqVl(reqVl),
    .elemCnt(elemIdx), .vlOut(finalVl), .excOut(exception),
    .illOut(illegal), .cntZero(cntZero), .lastElem(lastElem),
    .reqInZero(reqInZero)
  );

endmodule

// File: tb/sim_ffvl_top.sv
module sim_ffvl_top;
  localparam int CLK_PERIOD = 10;
  localparam int VLW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, baseIsVec = 1'b0, vertMode = 1'b0;
  logic elemAck = 1'b0, elemFault = 1'b0, stopReq = 1'b0;
  logic [VLW-1:0] reqVl = '0;
  logic elemReq, wbEn, cancel, exception, illegal, done;
  logic [VLW-1:0] elemIdx, finalVl;
  logic sElemReq, sWbEn, sCancel, sExc, sIll, sDone;
  logic [VLW-1:0] sIdx, sVl;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ffvl_top #(.MAX_VL(16)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .reqVl(reqVl),
    .baseIsVec(baseIsVec), .vertMode(vertMode), .elemReq(elemReq),
    .elemIdx(elemIdx), .elemAck(elemAck), .elemFault(elemFault),
    .stopReq(stopReq), .wbEn(wbEn), .cancel(cancel), .exception(exception),
    .illegal(illegal), .done(done), .finalVl(finalVl));

  ffvl_top #(.MAX_VL(16), .FORCE_SINGLE(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .start(start), .reqVl(reqVl),
    .baseIsVec(baseIsVec), .vertMode(vertMode), .elemReq(sElemReq),
    .elemIdx(sIdx), .elemAck(elemAck), .elemFault(elemFault),
    .stopReq(stopReq), .wbEn(sWbEn), .cancel(sCancel), .exception(sExc),
    .illegal(sIll), .done(sDone), .finalVl(sVl));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic startOp(input int vl, input bit bv, input bit vm);
    @(negedge clk);
    start = 1'b1; reqVl = VLW'(vl); baseIsVec = bv; vertMode = vm;
    @(negedge clk);
    start = 1'b0; baseIsVec = 1'b0; vertMode = 1'b0;
  endtask

  task automatic doElem(input int idx, input bit flt, input bit stp,
                        input bit expCancel, input bit expWb, input string tag);
    chk({tag, " elemReq"}, int'(elemReq), 1);
    chk({tag, " elemIdx"}, int'(elemIdx), idx);
    elemAck = 1'b1; elemFault = flt; stopReq = stp;
    #1;
    chk({tag, " cancel"}, int'(cancel), int'(expCancel));
    chk({tag, " wbEn"}, int'(wbEn), int'(expWb));
    @(negedge clk);
    elemAck = 1'b0; elemFault = 1'b0; stopReq = 1'b0;
  endtask

  task automatic endOp(input int expVl, input int expExc, input int expIll, input string tag);
    chk({tag, " done"}, int'(done), 1);
    chk({tag, " finalVl"}, int'(finalVl), expVl);
    chk({tag, " exception"}, int'(exception), expExc);
    chk({tag, " illegal"}, int'(illegal), expIll);
    chk({tag, " elemReq low (R9)"}, int'(elemReq), 0);
    @(negedge clk);
    chk({tag, " back idle (R9)"}, int'(elemReq), 0);
  endtask

  task automatic tReset();
    chk("R1 done", int'(done), 0);
    chk("R1 elemReq", int'(elemReq), 0);
    chk("R1 exception", int'(exception), 0);
    chk("R1 illegal", int'(illegal), 0);
    chk("R1 cancel", int'(cancel), 0);
    chk("R1 finalVl", int'(finalVl), 0);
  endtask

  task automatic tNoFault();
    startOp(4, 1'b0, 1'b0);
    doElem(0, 0, 0, 0, 1, "R2 e0");
    chk("R10 single done", int'(sDone), 1);
    chk("R10 single finalVl", int'(sVl), 1);
    for (int k = 1; k < 4; k++) doElem(k, 0, 0, 0, 1, "R2 ek");
    endOp(4, 0, 0, "R2 end");
  endtask

  task automatic tFaultFirst();
    startOp(5, 1'b0, 1'b0);
    doElem(0, 1, 0, 0, 0, "R3 e0");
    endOp(5, 1, 0, "R3 end");
  endtask

  task automatic tFaultLater();
    startOp(6, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) doElem(k, 0, 0, 0, 1, "R4 ok");
    doElem(3, 1, 0, 1, 0, "R4 e3");
    endOp(3, 0, 0, "R4 end");
  endtask

  task automatic tStop();
    startOp(8, 1'b0, 1'b0);
    doElem(0, 0, 0, 0, 1, "R5 e0");
    doElem(1, 0, 1, 0, 1, "R5 e1");
    endOp(2, 0, 0, "R5 end");
  endtask

  task automatic tFaultAndStop();
    startOp(8, 1'b0, 1'b0);
    doElem(0, 0, 0, 0, 1, "R6 e0");
    doElem(1, 1, 1, 1, 0, "R6 e1");
    endOp(1, 0, 0, "R6 end");
  endtask

  task automatic tIllegal(input bit bv, input bit vm, input string tag);
    startOp(7, bv, vm);
    endOp(7, 0, 1, tag);
  endtask

  task automatic tBusyStart();
    startOp(3, 1'b0, 1'b0);
    start = 1'b1; reqVl = VLW'(2);
    doElem(0, 0, 0, 0, 1, "R9 e0");
    start = 1'b0;
    doElem(1, 0, 0, 0, 1, "R9 e1");
    doElem(2, 0, 0, 0, 1, "R9 e2");
    endOp(3, 0, 0, "R9 end");
  endtask

  task automatic tZero();
    startOp(0, 1'b0, 1'b0);
    endOp(0, 0, 0, "R11 end");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tNoFault();
    tFaultFirst();
    tFaultLater();
    tStop();
    tFaultAndStop();
    tIllegal(1'b1, 1'b0, "R7 base vector");
    tIllegal(1'b0, 1'b1, "R8 vertical");
    tBusyStart();
    tZero();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule